// File: doc/BRIEF.md
# Guarded Watchdog Timer

This block watches for a stalled program. A watchdog tick, supplied from outside at some slower rate, drives a free-running prescaler. A tap on that prescaler, picked by a 3-bit period code, advances a small overflow counter. When the overflow counter wraps, the block raises a reset request for one clock cycle. Software keeps this from happening by pulsing the restart input often enough, which clears both counters.

Software sees one byte-wide control register, with a write port and a combinational read port. Turning the watchdog on is always allowed. Turning it off, or changing the period code, needs a timed unlock. First comes an arming write with both the unlock bit and the enable bit set. A follow-up write must then land within the next four clock cycles. A static lock input, which must only change while reset is held, selects between two modes. In the optional mode, the watchdog comes out of reset disabled. In the forced mode, it comes out enabled and can never be turned off, although its period can still be changed through the unlock.

Top module: `wdg_guard`

## Requirements
- R1: After reset the register reads 0x00 when `safe_lock` is 0, and 0x08 (enabled, period code 0) when `safe_lock` is 1.
- R2: Read layout: bit 4 is the unlock-window flag, bit 3 is the enable, and bits 2:0 are the period code. Bits 7:5 always read zero, even after a write of ones to them.
- R3: A write with bits 4 and 3 both set is an arming write. It opens the window, and bit 4 then reads 1 for exactly four cycles before reading 0. Any other write made while the window is open closes it; a second arming write restarts it.
- R4: Writing 0 to the enable bit clears it only if the write lands while the window is open and `safe_lock` is 0. Otherwise the enable keeps its value. Writing 1 to the enable bit always sets it.
- R5: A write updates the period code only while the window is open. At any other time the code is left unchanged.
- R6: While enabled, with period code k and both counters clear, `rst_req` is high in the cycle after the (8·2^k)-th watchdog tick. Ticks are counted, not clock cycles.
- R7: `rst_req` is high for a single cycle. Both counters then restart from zero, so the next request comes after another 8·2^k ticks.
- R8: A cycle with `kick` high clears both counters, and no request follows in the next cycle.
- R9: While disabled, `rst_req` stays low and both counters are held clear. After the watchdog is enabled, the first request comes after a full period.
- R10: With `safe_lock` at 1, the enable bit always reads 1. The period code still changes only through the window.
- R11: A change of the period code clears both counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low chip reset |
| safe_lock | input | 1 | Static mode: 0 = optional watchdog, 1 = forced on |
| wd_tick | input | 1 | One-cycle watchdog time-base tick |
| kick | input | 1 | Restart strobe from software |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| ctl_rdata | output | 8 | Control register read data |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
A stale prescaler or overflow count shows up at the ports as a reset request that comes too early or too late. The bench counts the ticks to the first request after a restart, a period change or an enable, and compares that count with 8·2^k for each of the eight codes. A wrong window count shows at once on the read port, because bit 4 drops a cycle early or late. It also shows as a disable or period write that lands one cycle outside the window but is accepted, or one inside the window that is refused, and the next read exposes it.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int SEL_W = 3;
  localparam int PRE_W = (1 << SEL_W) - 1;
  localparam int CTL_W = 8;

  typedef struct packed {
    logic [2:0]       rsvd;
    logic             chg;
    logic             en;
    logic [SEL_W-1:0] sel;
  } ctl_t;

  // low-bit mask that selects prescaler tap 2^s
  function automatic logic [PRE_W-1:0] tap_mask(input logic [SEL_W-1:0] s);
    logic [PRE_W:0] m;
    m = ({{PRE_W{1'b0}}, 1'b1} << s) - 1'b1;
    return m[PRE_W-1:0];
  endfunction

  // ticks from clear to reset request
  function automatic int unsigned timeout_ticks(input int unsigned cnt_w,
                                                input int unsigned s);
    return (32'd1 << cnt_w) << s;
  endfunction
endpackage

// File: rtl/wdg_ctrl.sv
module wdg_ctrl
  import wdg_pkg::*;
#(
  parameter int WIN_CYC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             safe_lock,
  input  logic             we,
  input  logic             wr_chg,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  output logic             en_eff,
  output logic             win_open,
  output logic [SEL_W-1:0] sel,
  output logic             sel_chg
);
  localparam int WIN_W = $clog2(WIN_CYC + 1);

  logic [WIN_W-1:0] win_cnt;
  logic             en_q, en_d;
  logic [SEL_W-1:0] sel_q, sel_d;
  logic             arm;

  assign win_open = (win_cnt != '0);
  assign arm      = we && wr_chg && wr_en;

  always_comb begin
    en_d  = en_q;
    sel_d = sel_q;
    if (we) begin
      if (wr_en)                       en_d = 1'b1;
      else if (win_open && !safe_lock) en_d = 1'b0;
      if (win_open)                    sel_d = wr_sel;
    end
  end

  assign sel_chg = (sel_d != sel_q);
  assign en_eff  = en_q | safe_lock;
  assign sel     = sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= safe_lock;
      sel_q   <= '0;
      win_cnt <= '0;
    end else begin
      en_q  <= en_d | safe_lock;
      sel_q <= sel_d;
      if (arm)                 win_cnt <= WIN_W'(WIN_CYC);
      else if (we && win_open) win_cnt <= '0;
      else if (win_open)       win_cnt <= win_cnt - 1'b1;
    end
  end
endmodule

// File: rtl/wdg_timebase.sv
module wdg_timebase
  import wdg_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             kick,
  input  logic             sel_chg,
  input  logic [SEL_W-1:0] sel,
  output logic             step,
  output logic             fire,
  output logic             rst_req
);
  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] cnt_q;
  logic [PRE_W-1:0] mask;
  logic             wrap, clr;

  assign mask = tap_mask(sel);
  assign step = run && tick && ((pre_q & mask) == mask);
  assign wrap = step && (cnt_q == '1);
  assign clr  = !run || kick || sel_chg || wrap;
  assign fire = wrap && !kick && !sel_chg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q   <= '0;
      cnt_q   <= '0;
      rst_req <= 1'b0;
    end else begin
      rst_req <= fire;
      if (clr) begin
        pre_q <= '0;
        cnt_q <= '0;
      end else if (tick) begin
        pre_q <= pre_q + 1'b1;
        if (step) cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/wdg_guard.sv
module wdg_guard
  import wdg_pkg::*;
#(
  parameter int WIN_CYC = 4,
  parameter int CNT_W   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             safe_lock,
  input  logic             wd_tick,
  input  logic             kick,
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] ctl_wdata,
  output logic [CTL_W-1:0] ctl_rdata,
  output logic             rst_req
);
  ctl_t             wr;
  ctl_t             rd;
  logic             en_eff, win_open, sel_chg, step, fire;
  logic [SEL_W-1:0] sel;

  assign wr = ctl_t'(ctl_wdata);

  wdg_ctrl #(.WIN_CYC(WIN_CYC)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .safe_lock(safe_lock),
    .we(ctl_we), .wr_chg(wr.chg), .wr_en(wr.en), .wr_sel(wr.sel),
    .en_eff(en_eff), .win_open(win_open), .sel(sel), .sel_chg(sel_chg)
  );

  wdg_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk(clk), .rst_n(rst_n), .run(en_eff), .tick(wd_tick), .kick(kick),
    .sel_chg(sel_chg), .sel(sel), .step(step), .fire(fire), .rst_req(rst_req)
  );

  always_comb begin
    rd      = '0;
    rd.chg  = win_open;
    rd.en   = en_eff;
    rd.sel  = sel;
  end
  assign ctl_rdata = rd;
endmodule

// File: rtl/wdg_guard_chk.sv
module wdg_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       safe_lock,
  input logic       wd_tick,
  input logic       kick,
  input logic       ctl_we,
  input logic [7:0] ctl_wdata,
  input logic [7:0] ctl_rdata,
  input logic       rst_req,
  input logic       en_eff,
  input logic       win_open
);
  p_single_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && ctl_wdata[7:5] != 3'b000) |=> ctl_rdata[7:5] == 3'b000);

  p_locked_on_r10: assert property (@(posedge clk) disable iff (!rst_n)
    safe_lock |-> ctl_rdata[3]);

  p_quiet_when_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en_eff |=> !rst_req);

  p_arm_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(win_open) |-> $past(ctl_we && ctl_wdata[4] && ctl_wdata[3]));

  p_sel_guard_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !($past(ctl_we) && $past(win_open)) |-> $stable(ctl_rdata[2:0]));

  p_en_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en_eff) |-> $past(ctl_we && win_open && !safe_lock && !ctl_wdata[3]));

  p_fire_needs_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> $past(wd_tick && !kick));

  p_kick_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> !rst_req);
endmodule

bind wdg_guard wdg_guard_chk u_chk (
  .clk(clk), .rst_n(rst_n), .safe_lock(safe_lock), .wd_tick(wd_tick),
  .kick(kick), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
  .rst_req(rst_req), .en_eff(en_eff), .win_open(win_open)
);

// File: tb/wdg_guard_bench.sv
`timescale 1ns/1ps
module wdg_guard_bench;
  localparam int CNT_W = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       safe_lock = 1'b0;
  logic       wd_tick = 1'b0;
  logic       kick = 1'b0;
  logic       ctl_we = 1'b0;
  logic [7:0] ctl_wdata = 8'h00;
  logic [7:0] ctl_rdata;
  logic       rst_req;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  wdg_guard u_wdg_guard (
    .clk(clk), .rst_n(rst_n), .safe_lock(safe_lock), .wd_tick(wd_tick),
    .kick(kick), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .rst_req(rst_req)
  );

  function automatic int period_of(input int k);
    return (1 << CNT_W) * (1 << k);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic adv();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset(input logic lock);
    rst_n = 1'b0;
    safe_lock = lock;
    adv(); adv();
    rst_n = 1'b1;
    adv();
  endtask

  task automatic wr(input logic [7:0] d);
    ctl_we = 1'b1; ctl_wdata = d;
    adv();
    ctl_we = 1'b0; ctl_wdata = 8'h00;
  endtask

  task automatic do_kick();
    kick = 1'b1; adv(); kick = 1'b0;
  endtask

  task automatic set_period(input int k);
    wr(8'h18);
    wr(8'h08 | 8'(k));
  endtask

  // returns the index of the tick after which rst_req rose, 0 if none
  task automatic run_ticks(input int maxn, input int gap, output int first);
    first = 0;
    for (int i = 1; i <= maxn; i++) begin
      wd_tick = 1'b1; adv(); wd_tick = 1'b0;
      if (rst_req) begin first = i; return; end
      for (int g = 0; g < gap; g++) adv();
    end
  endtask

  initial begin
    int f;
    int ones;
    @(negedge clk);
    // ---- optional mode ----
    do_reset(1'b0);
    chk("R1 reset read optional", ctl_rdata, 8'h00);
    run_ticks(50, 0, f);
    chk("R9 disabled after reset no request", f, 0);

    wr(8'h08);
    chk("R4 enable set by plain write", ctl_rdata[3], 1);

    // R6 / R7 sweep across all period codes
    for (int k = 0; k < 8; k++) begin
      set_period(k);
      chk($sformatf("R5 period code %0d via window", k), ctl_rdata[2:0], k);
      do_kick();
      run_ticks(period_of(k) + 4, 0, f);
      chk($sformatf("R6 timeout code %0d", k), f, period_of(k));
      adv();
      chk($sformatf("R7 pulse width code %0d", k), rst_req, 0);
      run_ticks(period_of(k) + 4, 0, f);
      chk($sformatf("R7 repeat period code %0d", k), f, period_of(k));
    end

    // R6 sparse ticks count ticks not cycles
    set_period(2);
    do_kick();
    run_ticks(40, 2, f);
    chk("R6 sparse ticks", f, 32);

    // R8 kick restarts
    set_period(1);
    do_kick();
    run_ticks(15, 0, f);
    chk("R8 no request before kick", f, 0);
    do_kick();
    chk("R8 no request after kick", rst_req, 0);
    run_ticks(20, 0, f);
    chk("R8 full period after kick", f, 16);

    // R11 period change clears counters
    set_period(3);
    do_kick();
    run_ticks(40, 0, f);
    chk("R11 partial run quiet", f, 0);
    set_period(2);
    run_ticks(40, 0, f);
    chk("R11 period change clears", f, 32);

    // R5 period write outside window ignored
    wr(8'h0B);
    chk("R5 sel write outside window", ctl_rdata[2:0], 2);

    // R2 reserved bits
    wr(8'hEA);
    chk("R2 reserved read zero", ctl_rdata[7:5], 0);
    chk("R2 enable after reserved write", ctl_rdata[3], 1);

    // R3 window length
    wr(8'h18);
    ones = 0;
    for (int c = 0; c < 6; c++) begin
      if (ctl_rdata[4]) ones++;
      adv();
    end
    chk("R3 window four cycles", ones, 4);
    wr(8'h18);
    wr(8'h08 | 8'd2);
    chk("R3 follow-up write closes window", ctl_rdata[4], 0);

    // R4 disable attempts
    set_period(0);
    wr(8'h00);
    chk("R4 clear without unlock ignored", ctl_rdata[3], 1);
    wr(8'h18);
    adv(); adv(); adv(); adv();
    wr(8'h00);
    chk("R4 clear one cycle late ignored", ctl_rdata[3], 1);
    wr(8'h18);
    adv(); adv(); adv();
    wr(8'h00);
    chk("R4 clear on last window cycle", ctl_rdata, 8'h00);
    run_ticks(100, 0, f);
    chk("R9 disabled no request", f, 0);
    wr(8'h08);
    run_ticks(20, 0, f);
    chk("R9 full period after enable", f, 8);

    // ---- forced mode ----
    do_reset(1'b1);
    chk("R1 reset read forced", ctl_rdata, 8'h08);
    wr(8'h18);
    wr(8'h00);
    chk("R10 cannot disable", ctl_rdata[3], 1);
    wr(8'h0D);
    chk("R10 sel needs window", ctl_rdata[2:0], 0);
    set_period(5);
    chk("R10 sel through window", ctl_rdata[2:0], 5);
    do_kick();
    run_ticks(period_of(5) + 4, 0, f);
    chk("R10 forced mode timeout", f, period_of(5));

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule